// File: doc/BRIEF.md
# Dual-Enable SRAM Device Port

This block is the device-facing side of a byte-wide static memory. A bus master drives an active-low select, an active-high select, an active-low output enable and an active-low write enable, together with an address and a write byte. The port decodes these pins into idle, read and write behaviour. It drives a three-state byte bus, which appears as a data value plus a drive enable, and it stores bytes in an internal array. The array is 2^ADDR_W bytes deep. Setting ADDR_W to 13 gives 8K x 8. A lock input from a supply monitor forces the port off the bus and blocks all stores.

All pins are treated as asynchronous. The select, enable and lock pins each pass through a two-flop synchroniser. The address and data pins go through an equal-depth register chain, so that each sample stays aligned with its control sample. A pin change therefore reaches the outputs on the third rising edge after the edge that first samples it. A write window opens when the last of its three conditions becomes true: write enable low, low select low, high select high. It closes as soon as the first of them becomes false. The byte and address seen in the final sampled cycle of the window are stored when the window closes.

The control state machine has four states.
- ST_IDLE: not selected.
- ST_READ: selected with write enable high.
- ST_WRITE: the write window is open.
- ST_PROT: locked.

Every state computes its next state by the same priority.
- LOCK: go to ST_PROT when lock is high.
- OPEN: otherwise go to ST_WRITE when the write conditions all hold.
- SELECT: otherwise go to ST_READ when both selects are active.
- DROP: otherwise go to ST_IDLE.

Leaving ST_WRITE by SELECT or DROP commits the captured byte. Leaving it by LOCK discards the byte.

Top module: `sram_port`

## Requirements
- R1: When the low select is high or the high select is low, dq_oe is 0. This also holds from reset until the first pin samples have propagated.
- R2: With lock low, both selects active, we_n high and oe_n low, dq_oe is 1 and dq_out carries the byte stored at addr, three rising edges after the pins are sampled. With oe_n high, dq_oe is 0.
- R3: A write window stores din into the addressed location. A read that follows the write, including one that starts on the very cycle the window closes, returns the new byte.
- R4: The write window opens on whichever of we_n falling, cs_n falling or cs rising comes last, and it closes on whichever of these returns first. Each of the three pins can end the write.
- R5: When din changes during an open window, the value present in the final sampled cycle of the window is the one stored.
- R6: While we_n is low, dq_oe is 0 even with oe_n low. Dropping we_n during a read turns the bus off.
- R7: With oe_n already low, if a select asserts on the same edge as we_n falls, dq_oe stays 0 throughout.
- R8: While lock is high, dq_oe is 0, all other pins are ignored, and a write attempted under lock leaves memory unchanged.
- R9: If lock rises while a write window is open, the write is abandoned and the location keeps its previous byte.
- R10: dq_out reads 0 whenever dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| cs | input | 1 | Active-high select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| lock | input | 1 | Forces deselection and write protection |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte to write |
| dq_out | output | DATA_W | Byte driven onto the bus, zero when not driving |
| dq_oe | output | 1 | Bus drive enable; low means high impedance |

## Verification
Writes are framed three ways: by write enable, by the low select and by the high select. Each pin finishes last in one frame and first in another, which shows that the window is bounded by the latest start and the earliest end rather than by any single pin. A window whose data changes partway through separates storing at the end from storing at the start. A read that begins on the same edge the window closes exercises the path where the written byte is passed straight to the output. Lock is raised once while idle with a write attempted and once in the middle of an open window, and each address is read back afterwards, which separates a blocked write from a completed one. A select asserting on the same edge as write enable falls, with output enable already low, shows whether the bus ever glitches on.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

    // Control state of the port
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_PROT  = 2'd3
    } port_state_e;

    // Synchronised control pins, packed in pin-vector order
    typedef struct packed {
        logic sel_n;
        logic sel;
        logic rd_n;
        logic wr_n;
        logic lock;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Inactive pin values loaded into the synchronisers at reset
    localparam ctrl_t CTRL_REST = '{sel_n: 1'b1, sel: 1'b0, rd_n: 1'b1, wr_n: 1'b1, lock: 1'b0};

endpackage

// File: rtl/sram_port_sync.sv
module sram_port_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sram_port_fsm.sv
module sram_port_fsm
    import sram_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctl,
    output logic  capture,
    output logic  commit,
    output logic  drive_d,
    output logic  dq_oe
);

    port_state_e state_q, state_d, target;
    logic        chosen, wr_ok;

    // Priority shared by every state: LOCK, OPEN, SELECT, DROP
    always_comb begin
        chosen = !ctl.sel_n && ctl.sel;
        wr_ok  = chosen && !ctl.wr_n;
        if (ctl.lock)  target = ST_PROT;
        else if (wr_ok) target = ST_WRITE;
        else if (chosen) target = ST_READ;
        else            target = ST_IDLE;
    end

    always_comb begin
        state_d = target;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE:  state_d = target;
            ST_READ:  state_d = target;
            ST_WRITE: begin
                state_d = target;
                // window closes by SELECT or DROP: keep the byte; by LOCK: discard
                commit  = (target == ST_READ) || (target == ST_IDLE);
            end
            ST_PROT:  state_d = target;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign capture = (state_d == ST_WRITE);
    assign drive_d = (state_d == ST_READ) && !ctl.rd_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dq_oe <= 1'b0;
        else        dq_oe <= drive_d;
    end

endmodule

// File: rtl/sram_port_store.sv
module sram_port_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              commit,
    input  logic              drive_d,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dq_out
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [DATA_W-1:0] rd_word;

    // Track the latest address and byte while the window is open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (capture) begin
            cap_addr <= addr;
            cap_data <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (commit) mem[cap_addr] <= cap_data;
    end

    // A read starting on the closing cycle sees the byte being committed
    always_comb begin
        if (commit && (cap_addr == addr)) rd_word = cap_data;
        else                              rd_word = mem[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dq_out <= '0;
        else if (drive_d) dq_out <= rd_word;
        else              dq_out <= '0;
    end

endmodule

// File: rtl/sram_port.sv
module sram_port
    import sram_port_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cs,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lock,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam int PATH_W = ADDR_W + DATA_W;

    logic [CTRL_W-1:0] ctl_raw;
    logic [PATH_W-1:0] path_raw;
    ctrl_t             ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    logic              capture, commit, drive_d;

    sram_port_sync #(
        .WIDTH   (CTRL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTRL_REST)
    ) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, cs, oe_n, we_n, lock}),
        .q     (ctl_raw)
    );

    // Address and data ride an equal-depth chain to stay aligned with control
    sram_port_sync #(
        .WIDTH   (PATH_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_path_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr, din}),
        .q     (path_raw)
    );

    assign ctl_s           = ctl_raw;
    assign {addr_s, din_s} = path_raw;

    sram_port_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl_s),
        .capture (capture),
        .commit  (commit),
        .drive_d (drive_d),
        .dq_oe   (dq_oe)
    );

    sram_port_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .commit  (commit),
        .drive_d (drive_d),
        .addr    (addr_s),
        .din     (din_s),
        .dq_out  (dq_out)
    );

endmodule

// File: rtl/sram_port_chk.sv
module sram_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              cs,
    input logic              oe_n,
    input logic              we_n,
    input logic              lock,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);

    // Cycles since reset, saturating at the pin-to-output latency
    logic [1:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    assert_desel_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 3) || !$past(cs, 3)) |-> !dq_oe);

    assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen == 2'd3) && !$past(lock, 3) && !$past(cs_n, 3) && $past(cs, 3)
         && $past(we_n, 3) && !$past(oe_n, 3)) |-> dq_oe);

    assert_oe_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n, 3) |-> !dq_oe);

    assert_we_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we_n, 3) |-> !dq_oe);

    assert_lock_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock, 3) |-> !dq_oe);

    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));

endmodule

bind sram_port sram_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .cs     (cs),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .lock   (lock),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
);

// File: tb/sram_port_test.sv
`timescale 1ns/1ps
module sram_port_test;

    localparam int AW = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, cs = 1'b0, oe_n = 1'b1, we_n = 1'b1, lock = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #5 clk = ~clk;

    sram_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs(cs), .oe_n(oe_n), .we_n(we_n),
        .lock(lock), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // ---------------- behavioural reference model ----------------
    typedef struct { bit cs_n; bit cs; bit oe_n; bit we_n; bit lock; int a; int d; } smp_t;
    smp_t hist[$];
    int   mem_m[int];
    bit   win;
    int   wa, wd;
    bit   e_oe;
    int   e_out;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist.delete();
            win = 0; e_oe = 0; e_out = 0;
        end else begin
            smp_t s, h;
            bit wr, sel;
            s.cs_n = cs_n; s.cs = cs; s.oe_n = oe_n; s.we_n = we_n; s.lock = lock;
            s.a = int'(addr); s.d = int'(din);
            hist.push_back(s);
            if (hist.size() > 2) begin
                h   = hist.pop_front();
                sel = !h.cs_n && h.cs;
                wr  = sel && !h.we_n && !h.lock;
                if (win && !wr && !h.lock) mem_m[wa] = wd;
                if (wr) begin wa = h.a; wd = h.d; end
                win  = wr;
                e_oe = !h.lock && sel && h.we_n && !h.oe_n;
                if (e_oe) e_out = mem_m.exists(h.a) ? mem_m[h.a] : -1;
                else      e_out = 0;
            end else begin
                e_oe = 0; e_out = 0;
            end
        end
    end

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dq_oe !== e_oe || dq_out !== e_out[DW-1:0]) begin
                errors++;
                $display("FAIL %s: model mismatch oe=%0b out=%02h expected oe=%0b out=%02h",
                         cur_req, dq_oe, dq_out, e_oe, e_out[DW-1:0]);
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_pins();
        cs_n = 1; cs = 0; oe_n = 1; we_n = 1;
    endtask

    // Plain write framed by write enable
    task automatic wr_byte(input int a, input int d);
        @(negedge clk); addr = a[AW-1:0]; din = d[DW-1:0]; cs_n = 0; cs = 1; oe_n = 1;
        wait_n(1); we_n = 0;
        wait_n(4); we_n = 1;
        wait_n(1); idle_pins();
        wait_n(4);
    endtask

    task automatic rd_byte(input string req, input int a, input int d);
        @(negedge clk); addr = a[AW-1:0]; cs_n = 0; cs = 1; we_n = 1; oe_n = 0;
        wait_n(4);
        check(req, dq_oe, 1);
        check(req, dq_out, d);
        oe_n = 1; idle_pins();
        wait_n(4);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_n(4);
        check("R1", dq_oe, 0);
        check("R10", dq_out, 0);
        @(negedge clk); rst_n = 1;
        wait_n(3);
        check("R1", dq_oe, 0);

        // R3 / R4: write framed by write enable, then read back
        cur_req = "R3";
        wr_byte(5, 8'h3C);
        rd_byte("R3", 5, 8'h3C);

        // R4: low select frames the write (we_n and cs already set)
        cur_req = "R4";
        @(negedge clk); addr = 10'd6; din = 8'hA1; we_n = 0; cs = 1; oe_n = 1;
        wait_n(2); cs_n = 0;
        wait_n(3); cs_n = 1;
        wait_n(2); idle_pins(); wait_n(4);
        rd_byte("R4", 6, 8'hA1);

        // R4: high select frames the write
        @(negedge clk); addr = 10'd7; din = 8'h5E; we_n = 0; cs_n = 0; oe_n = 1;
        wait_n(2); cs = 1;
        wait_n(3); cs = 0;
        wait_n(2); idle_pins(); wait_n(4);
        rd_byte("R4", 7, 8'h5E);

        // R5: data changes inside the window; the last value is kept
        cur_req = "R5";
        @(negedge clk); addr = 10'd9; din = 8'h11; cs_n = 0; cs = 1; oe_n = 1;
        wait_n(1); we_n = 0;
        wait_n(3); din = 8'h22;
        wait_n(3); din = 8'h33;
        wait_n(1); we_n = 1;
        wait_n(1); din = 8'h44;
        wait_n(1); idle_pins(); wait_n(4);
        rd_byte("R5", 9, 8'h33);

        // R6: dropping we_n during a read turns the bus off
        cur_req = "R6";
        @(negedge clk); addr = 10'd5; din = 8'h3C; cs_n = 0; cs = 1; we_n = 1; oe_n = 0;
        wait_n(4);
        check("R6", dq_oe, 1);
        we_n = 0;
        wait_n(4);
        check("R6", dq_oe, 0);
        check("R10", dq_out, 0);
        // R3: window closes straight into a read of the same address
        cur_req = "R3";
        din = 8'h77;
        wait_n(1); we_n = 1;
        wait_n(4);
        check("R3", dq_oe, 1);
        check("R3", dq_out, 8'h77);
        oe_n = 1; idle_pins(); wait_n(4);

        // R7: select asserts on the same edge as we_n falls, oe_n already low
        cur_req = "R7";
        @(negedge clk); addr = 10'd12; din = 8'hC3; oe_n = 0; we_n = 1; cs = 1; cs_n = 1;
        wait_n(3);
        cs_n = 0; we_n = 0;
        for (int i = 0; i < 6; i++) begin
            wait_n(1);
            check("R7", dq_oe, 0);
        end
        we_n = 1; cs_n = 1;
        wait_n(1); idle_pins(); wait_n(4);
        rd_byte("R7", 12, 8'hC3);

        // R8: lock blocks reads and writes
        cur_req = "R8";
        @(negedge clk); lock = 1;
        wait_n(1);
        addr = 10'd5; din = 8'hEE; cs_n = 0; cs = 1; oe_n = 1;
        wait_n(1); we_n = 0; wait_n(4); we_n = 1; wait_n(1);
        oe_n = 0;
        wait_n(4);
        check("R8", dq_oe, 0);
        check("R8", dq_out, 0);
        idle_pins();
        wait_n(2); lock = 0; wait_n(4);
        rd_byte("R8", 5, 8'h77);

        // R9: lock raised mid-window abandons the write
        cur_req = "R9";
        @(negedge clk); addr = 10'd9; din = 8'h99; cs_n = 0; cs = 1; oe_n = 1;
        wait_n(1); we_n = 0;
        wait_n(4); lock = 1;
        wait_n(3); we_n = 1;
        wait_n(2); idle_pins();
        wait_n(2); lock = 0; wait_n(4);
        rd_byte("R9", 9, 8'h33);

        // R1 / R2: deselect with oe_n low via each select
        cur_req = "R1";
        @(negedge clk); addr = 10'd6; cs_n = 0; cs = 1; we_n = 1; oe_n = 0;
        wait_n(4);
        check("R2", dq_oe, 1);
        check("R2", dq_out, 8'hA1);
        cs = 0;
        wait_n(4);
        check("R1", dq_oe, 0);
        cs = 1; cs_n = 1;
        wait_n(4);
        check("R1", dq_oe, 0);
        check("R10", dq_out, 0);
        cs_n = 0; oe_n = 1;
        wait_n(4);
        check("R2", dq_oe, 0);
        idle_pins();
        wait_n(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule